// File: doc/BRIEF.md
# Serial Character Transmitter with Clear-to-Send Pacing

This block turns bytes into asynchronous serial characters on a single line. Each character has one low start bit, eight data bits sent least significant bit first, and one high stop bit. Bytes arrive over a valid/ready handshake. Bit timing comes from an external baud tick, and each bit lasts a fixed number of ticks. Between characters the line rests high.

A mode input turns on pacing by an active-low clear-to-send input. With pacing on, a peer that raises clear-to-send (negates it) never cuts a character short.

- If the negation is seen in the first half of the character in flight, that character is the last one sent.
- If the negation is seen in the second half, one further whole character may still go out.

While clear-to-send stays negated the line rests high and no byte is taken. When clear-to-send is asserted again, sending continues with the next byte that is waiting. No error status exists, and none is raised. With the mode input low, clear-to-send has no effect.

Top module: `uart_cts_tx`

## Requirements
- R1: Each character is a low start bit, then the data bits with bit 0 first, then a high stop bit. Every bit lasts TICKS_PER_BIT baud ticks (default 4). The line is high whenever no character is being sent.
- R2: A byte is taken on a clock edge where in_valid and in_ready are both high. In the cycle after that, in_ready is low, and it stays low until the character's stop bit has ended.
- R3: With flow_en low, cts_n has no effect: every byte offered is sent in order, whatever cts_n does.
- R4: With flow_en high and cts_n held high (negated), while no character is in flight, no character starts: txd stays high and in_ready stays low.
- R5: With flow_en high, a negation of cts_n can be seen at a point where the current character has counted at most half of its frame's ticks (5*TICKS_PER_BIT, the exact midpoint included). In that case the character completes and no further character is sent while cts_n stays negated.
- R6: With flow_en high, a negation can be seen after more than half of the frame's ticks have been counted. In that case exactly one more whole character is sent after the current one, and sending then halts while cts_n stays negated.
- R7: After cts_n is asserted again (low), sending resumes with the next waiting byte. No byte is lost, repeated or reordered, and no error indication is produced.
- R8: After reset, txd is high, and with flow_en low in_ready is high. A character that has started always runs through its stop bit, even if cts_n is negated while it is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flow_en | input | 1 | 1 turns on clear-to-send pacing, 0 ignores cts_n |
| cts_n | input | 1 | Active-low clear-to-send from the peer, asynchronous |
| baud_tick | input | 1 | One-cycle pulse that advances bit timing |
| in_valid | input | 1 | A byte is offered on in_data |
| in_data | input | DATA_W | Byte to send |
| in_ready | output | 1 | The offered byte is taken on this edge if in_valid is high |
| txd | output | 1 | Serial line output, rests high |

## Verification
Fixed bytes 00, FF, A5 and 01 separate bit order, start and stop polarity, and stuck data bits. Random bytes with pacing off, while cts_n toggles at random, show that clear-to-send is truly ignored. Negations placed early and late in a character separate the one-character rule from the two-character rule. The baud tick is then frozen with exactly 20 and exactly 21 ticks counted, so a negation lands on each side of the midpoint and the inclusive boundary is pinned down. A final random run with pacing on and cts_n pulsing irregularly compares the whole received stream to the sent stream, to catch lost, repeated or reordered bytes.

// File: rtl/uart_cts_pkg.sv
package uart_cts_pkg;
  typedef enum logic {
    TX_IDLE  = 1'b0,
    TX_SHIFT = 1'b1
  } tx_state_t;
endpackage

// File: rtl/uart_cts_sync.sv
module uart_cts_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RESET_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_cts_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 4,
  localparam int FRAME_BITS   = DATA_W + 2,
  localparam int FRAME_TICKS  = FRAME_BITS * TICKS_PER_BIT,
  localparam int ELW          = $clog2(FRAME_TICKS + 1),
  localparam int SUBW         = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1,
  localparam int BITW         = $clog2(FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              start,
  input  logic [DATA_W-1:0] start_data,
  output logic              busy,
  output logic [ELW-1:0]    elapsed,
  output logic              txd
);
  tx_state_t       state_q;
  logic [SUBW-1:0] sub_q;
  logic [BITW-1:0] bit_q;
  logic [ELW-1:0]  elapsed_q;
  logic [DATA_W:0] shift_q;
  logic            txd_q;
  logic            last_sub, last_bit, frame_end;

  assign last_sub  = (sub_q == SUBW'(TICKS_PER_BIT - 1));
  assign last_bit  = (bit_q == BITW'(FRAME_BITS - 1));
  assign frame_end = baud_tick && last_sub && last_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= TX_IDLE;
      sub_q     <= '0;
      bit_q     <= '0;
      elapsed_q <= '0;
      shift_q   <= '1;
      txd_q     <= 1'b1;
    end else begin
      case (state_q)
        TX_IDLE: begin
          txd_q <= 1'b1;
          if (start) begin
            state_q   <= TX_SHIFT;
            sub_q     <= '0;
            bit_q     <= '0;
            elapsed_q <= '0;
            shift_q   <= {1'b1, start_data};
            txd_q     <= 1'b0;
          end
        end
        default: begin
          if (baud_tick) begin
            elapsed_q <= elapsed_q + ELW'(1);
            if (last_sub) begin
              sub_q <= '0;
              if (last_bit) begin
                state_q <= TX_IDLE;
                txd_q   <= 1'b1;
              end else begin
                bit_q   <= bit_q + BITW'(1);
                txd_q   <= shift_q[0];
                shift_q <= {1'b1, shift_q[DATA_W:1]};
              end
            end else begin
              sub_q <= sub_q + SUBW'(1);
            end
          end
        end
      endcase
    end
  end

  assign busy    = (state_q == TX_SHIFT);
  assign elapsed = elapsed_q;
  assign txd     = txd_q;

  p_idle_mark_r1: assert property (@(posedge clk) disable iff (rst)
    (state_q == TX_IDLE) |-> txd_q);
  p_start_low_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd_q);
  p_no_abort_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !frame_end) |=> busy);
endmodule

// File: rtl/uart_cts_gate.sv
module uart_cts_gate #(
  parameter int TICKS_PER_BIT = 4,
  parameter int FRAME_BITS    = 10,
  parameter int ELW           = 6,
  localparam int HALF_TICKS   = (FRAME_BITS * TICKS_PER_BIT) / 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           flow_en,
  input  logic           cts_s,
  input  logic           busy,
  input  logic           start,
  input  logic [ELW-1:0] elapsed,
  output logic           allow
);
  logic cts_d_q;
  logic extra_q;
  logic negation;
  logic late_half;

  assign negation  = cts_s && !cts_d_q;
  assign late_half = (elapsed > ELW'(HALF_TICKS));

  always_ff @(posedge clk) begin
    if (rst) begin
      cts_d_q <= 1'b1;
      extra_q <= 1'b0;
    end else begin
      cts_d_q <= cts_s;
      if (!flow_en || !cts_s || start)
        extra_q <= 1'b0;
      else if (negation && busy && late_half)
        extra_q <= 1'b1;
    end
  end

  assign allow = !flow_en || !cts_s || extra_q;

  p_extra_late_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(extra_q) |-> ($past(busy) && ($past(elapsed) > ELW'(HALF_TICKS))));
  p_extra_once_r6: assert property (@(posedge clk) disable iff (rst)
    (start && extra_q) |=> !extra_q);
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx #(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 4,
  parameter int SYNC_STAGES   = 2,
  localparam int FRAME_BITS   = DATA_W + 2,
  localparam int FRAME_TICKS  = FRAME_BITS * TICKS_PER_BIT,
  localparam int ELW          = $clog2(FRAME_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flow_en,
  input  logic              cts_n,
  input  logic              baud_tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd
);
  logic           cts_s;
  logic           busy;
  logic           allow;
  logic           start;
  logic [ELW-1:0] elapsed;

  uart_cts_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .async_in(cts_n), .sync_out(cts_s)
  );

  uart_cts_gate #(.TICKS_PER_BIT(TICKS_PER_BIT), .FRAME_BITS(FRAME_BITS), .ELW(ELW)) u_gate (
    .clk(clk), .rst(rst), .flow_en(flow_en), .cts_s(cts_s), .busy(busy),
    .start(start), .elapsed(elapsed), .allow(allow)
  );

  uart_tx_frame #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_frame (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .start(start),
    .start_data(in_data), .busy(busy), .elapsed(elapsed), .txd(txd)
  );

  assign in_ready = !busy && allow;
  assign start    = in_valid && in_ready;

  p_take_then_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
  p_stay_blocked_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(flow_en) && flow_en && $past(cts_s) && cts_s && !$past(busy) && !$past(in_ready))
      |-> !in_ready);

  generate
    if (SYNC_STAGES == 2) begin : g_sync_chk
      p_sync_latency_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (cts_s == $past(cts_n, 2)));
    end
  endgenerate
endmodule

// File: tb/uart_cts_tx_bench.sv
`timescale 1ns/1ps
module uart_cts_tx_bench;
  localparam int DW  = 8;
  localparam int TPB = 4;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flow_en = 1'b0;
  logic cts_n = 1'b0;
  logic baud_tick = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, txd;

  uart_cts_tx #(.DATA_W(DW), .TICKS_PER_BIT(TPB)) u_uart_cts_tx (
    .clk(clk), .rst(rst), .flow_en(flow_en), .cts_n(cts_n), .baud_tick(baud_tick),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .txd(txd)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] sendbuf [256];
  logic [7:0] rxbuf [256];
  int wr_ptr = 0, acc_cnt = 0, rx_cnt = 0;
  int start_err = 0, stop_err = 0;

  bit tick_en = 1'b1, freeze_on = 1'b0, rand_cts = 1'b0;
  int freeze_at = 0, div_cnt = 0, tog_cnt = 5;

  bit mon_busy = 1'b0, pend = 1'b0;
  int mon_tcnt = 0, pbit = 0;
  logic [7:0] mon_byte = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // baud tick source, freezable at a chosen tick count
  always @(negedge clk) begin
    if (rst) begin
      div_cnt   = 0;
      baud_tick = 1'b0;
    end else begin
      div_cnt   = (div_cnt + 1) % DIV;
      baud_tick = tick_en && (div_cnt == 0) &&
                  !(freeze_on && mon_busy && mon_tcnt == freeze_at);
    end
  end

  // random clear-to-send toggling
  always @(negedge clk) begin
    if (rand_cts) begin
      if (tog_cnt == 0) begin
        cts_n   = ~cts_n;
        tog_cnt = $urandom_range(1, 300);
      end else tog_cnt--;
    end
  end

  // byte source
  always @(posedge clk) if (!rst && in_valid && in_ready) acc_cnt++;
  always @(negedge clk) begin
    in_valid = (acc_cnt < wr_ptr);
    in_data  = sendbuf[acc_cnt % 256];
  end

  // line receiver: samples the middle of each bit by counting ticks
  always @(posedge clk) begin
    if (!rst) begin
      if (!mon_busy && txd == 1'b0) begin
        mon_busy = 1'b1;
        mon_tcnt = 0;
        pend     = 1'b0;
      end
      if (mon_busy) begin
        if (pend) begin
          pend = 1'b0;
          if (pbit == 0) begin
            if (txd !== 1'b0) start_err++;
          end else if (pbit <= DW) begin
            mon_byte[pbit-1] = txd;
          end else begin
            if (txd !== 1'b1) stop_err++;
            rxbuf[rx_cnt % 256] = mon_byte;
            rx_cnt++;
            mon_busy = 1'b0;
          end
        end
        if (baud_tick) begin
          mon_tcnt++;
          if (mon_tcnt % TPB == TPB / 2) begin
            pend = 1'b1;
            pbit = mon_tcnt / TPB;
          end
        end
      end
    end
  end

  task automatic push(input logic [7:0] b);
    sendbuf[wr_ptr] = b;
    wr_ptr++;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rx(input int n, input int limit, input string req);
    int k;
    k = 0;
    while (rx_cnt < n && k < limit) begin
      @(negedge clk);
      k++;
    end
    check(rx_cnt >= n, req, rx_cnt, n);
  endtask

  task automatic wait_tcnt(input int v, input string req);
    int k;
    k = 0;
    while (!(mon_busy && mon_tcnt == v) && k < 2000) begin
      @(negedge clk);
      k++;
    end
    check(mon_busy && mon_tcnt == v, req, mon_tcnt, v);
  endtask

  task automatic compare(input int from, input int to, input string req);
    for (int i = from; i < to; i++)
      check(rxbuf[i] == sendbuf[i], req, rxbuf[i], sendbuf[i]);
  endtask

  // frozen-tick negation: expect `extra` characters after the one in flight
  task automatic midpoint_case(input int at, input int extra, input string req);
    int base;
    base = wr_ptr;
    for (int i = 0; i < 3; i++) push(8'($urandom_range(0, 255)));
    freeze_at = at;
    freeze_on = 1'b1;
    wait_tcnt(at, req);
    cts_n = 1'b1;
    wait_cycles(12);
    freeze_on = 1'b0;
    wait_cycles(800);
    check(rx_cnt == base + 1 + extra, req, rx_cnt, base + 1 + extra);
    cts_n = 1'b0;
    wait_rx(base + 3, 2000, "R7");
    compare(base, base + 3, "R7");
  endtask

  initial begin
    int seed_dummy, base;
    seed_dummy = $urandom(1234);
    wait_cycles(6);
    rst = 1'b0;
    wait_cycles(1);
    check(txd == 1'b1, "R8 reset txd", txd, 1);
    check(in_ready == 1'b1, "R8 reset ready", in_ready, 1);

    // directed patterns
    push(8'h00); push(8'hFF); push(8'hA5); push(8'h01);
    while (!mon_busy) @(negedge clk);
    wait_cycles(3);
    check(in_ready == 1'b0, "R2 ready low in frame", in_ready, 0);
    wait_rx(4, 3000, "R1");
    compare(0, 4, "R1");

    // pacing off: cts ignored
    rand_cts = 1'b1;
    for (int i = 0; i < 20; i++) push(8'($urandom_range(0, 255)));
    wait_rx(24, 6000, "R3");
    rand_cts = 1'b0;
    cts_n = 1'b0;
    compare(4, 24, "R3");

    // pacing on, negated while idle
    flow_en = 1'b1;
    cts_n = 1'b1;
    wait_cycles(10);
    push(8'h3C); push(8'hC3);
    wait_cycles(600);
    check(rx_cnt == 24, "R4 no start", rx_cnt, 24);
    check(txd == 1'b1, "R4 line idle", txd, 1);
    check(in_ready == 1'b0, "R4 ready low", in_ready, 0);
    cts_n = 1'b0;
    wait_rx(26, 2000, "R7");
    compare(24, 26, "R7");

    // early negation
    base = wr_ptr;
    push(8'h81); push(8'h7E); push(8'h55);
    wait_tcnt(4, "R5");
    cts_n = 1'b1;
    wait_cycles(700);
    check(rx_cnt == base + 1, "R5 early stop", rx_cnt, base + 1);
    check(txd == 1'b1, "R5 line idle", txd, 1);
    check(rxbuf[base] == sendbuf[base], "R8 frame completed", rxbuf[base], sendbuf[base]);
    cts_n = 1'b0;
    wait_rx(base + 3, 2000, "R7");
    compare(base, base + 3, "R7");

    // late negation
    base = wr_ptr;
    push(8'h12); push(8'h34); push(8'h56);
    wait_tcnt(30, "R6");
    cts_n = 1'b1;
    wait_cycles(800);
    check(rx_cnt == base + 2, "R6 one extra", rx_cnt, base + 2);
    check(in_ready == 1'b0, "R6 ready low", in_ready, 0);
    cts_n = 1'b0;
    wait_rx(base + 3, 2000, "R7");
    compare(base, base + 3, "R7");

    // exact midpoint and one tick past it
    midpoint_case(20, 0, "R5 midpoint");
    midpoint_case(21, 1, "R6 past midpoint");

    // random pacing with cts pulses
    base = wr_ptr;
    rand_cts = 1'b1;
    for (int i = 0; i < 40; i++) push(8'($urandom_range(0, 255)));
    wait_rx(base + 40, 60000, "R7 random");
    rand_cts = 1'b0;
    cts_n = 1'b0;
    compare(base, base + 40, "R7 random");

    // random bytes with clear-to-send held asserted
    base = wr_ptr;
    for (int i = 0; i < 20; i++) push(8'($urandom_range(0, 255)));
    wait_rx(base + 20, 6000, "R1 random");
    compare(base, base + 20, "R1 random");

    check(start_err == 0, "R1 start bits", start_err, 0);
    check(stop_err == 0, "R1 stop bits", stop_err, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule